// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer that steers a multicycle datapath through each instruction. A 4-bit state register holds one of ten step numbers, 0 to 9. The control lines for memory, the instruction latch, the program counter, the ALU operand and function selects and the register file depend only on that step. The next step depends on the current step and on the 6-bit opcode field of the latched instruction.

Every instruction starts with a fetch step (0) and a decode step (1). It then follows a fixed path for its class. A load takes five cycles, a store or a register-register operation takes four, and a conditional branch takes three. An unconditional jump also takes three. A synchronous reset puts the sequencer back at the fetch step.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is 0 (fetch), whatever the opcode and current state are.
- R2: In state 0, `mem_rd_en`, `ir_load` and `pc_load` are 1. `alu_b_sel`=01 (constant four), `alu_func_sel`=00 (add) and `pc_src_sel`=00 (ALU result). All other outputs are 0. The next state is always 1.
- R3: In state 1, `alu_b_sel`=11 (shifted immediate) and all other outputs are 0. The opcode picks the next state: 000000 goes to 6, 100011 and 101011 go to 2, 000100 goes to 8, and 000010 goes to 9.
- R4: In state 2, `alu_a_sel`=1 and `alu_b_sel`=10 (immediate), with everything else 0. Opcode 100011 leads to state 3. State 3 drives `mem_rd_en`=1 and `addr_from_alu`=1, then goes to state 4. State 4 drives `rf_wr_en`=1, `rf_dst_sel`=0 and `rf_wb_sel`=1, then goes to state 0.
- R5: In state 2, opcode 101011 leads to state 5. State 5 drives `mem_wr_en`=1 and `addr_from_alu`=1, then goes to state 0.
- R6: State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_func_sel`=10 (function field), then goes to state 7. State 7 drives `rf_wr_en`=1, `rf_dst_sel`=1 and `rf_wb_sel`=0, then goes to state 0.
- R7: State 8 drives `alu_a_sel`=1, `alu_func_sel`=01 (subtract), `pc_load_on_zero`=1 and `pc_src_sel`=01 (registered ALU output), then goes to state 0.
- R8: State 9 drives `pc_load`=1 and `pc_src_sel`=10 (jump target), then goes to state 0.
- R9: An opcode outside the five listed codes returns the sequencer to state 0. This applies in state 1, and in state 2 when the opcode is neither 100011 nor 101011.
- R10: The opcode has no effect in any state other than 1 and 2.
- R11: A reset that arrives in the decode step wins over dispatch: the next state is 0 even when the opcode names a valid class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the latched instruction |
| state_o | output | 4 | Current step number |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction latch enable |
| addr_from_alu | output | 1 | Memory address from ALU output register (1) or PC (0) |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_on_zero | output | 1 | PC write when ALU zero flag is set |
| pc_src_sel | output | 2 | PC source: 00 ALU, 01 ALU register, 10 jump target |
| alu_func_sel | output | 2 | ALU function: 00 add, 01 subtract, 10 from function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 four, 10 immediate, 11 shifted immediate |
| rf_wr_en | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination field: 0 rt, 1 rd |
| rf_wb_sel | output | 1 | Write-back data: 0 ALU register, 1 memory data |

## Verification
Two functions can meet in one cycle: synchronous reset and opcode dispatch in the decode step. The bench raises reset in the same cycle that a load opcode is presented in state 1. It then expects state 0 and the fetch controls on the next cycle, not state 2. A second collision comes from changing the opcode between decode and address computation. This turns a load into a store, or into an unlisted code, at state 2. The bench judges the result by the branch the reference model takes. All other cycles use a random opcode, to show that it is ignored there.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_MADDR  = 4'd2,
        S_LDMEM  = 4'd3,
        S_LDWB   = 4'd4,
        S_STMEM  = 4'd5,
        S_EXEC   = 4'd6,
        S_RWB    = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9
    } state_t;

    typedef enum logic [2:0] {
        OC_RTYPE,
        OC_LOAD,
        OC_STORE,
        OC_BRANCH,
        OC_JUMP,
        OC_OTHER
    } opclass_t;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_AREG = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;

    localparam logic [1:0] FN_ADD   = 2'b00;
    localparam logic [1:0] FN_SUB   = 2'b01;
    localparam logic [1:0] FN_FIELD = 2'b10;

    localparam logic [1:0] BS_REG   = 2'b00;
    localparam logic [1:0] BS_FOUR  = 2'b01;
    localparam logic [1:0] BS_IMM   = 2'b10;
    localparam logic [1:0] BS_IMMSH = 2'b11;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_ld;
        logic       addr_alu;
        logic       pc_ld;
        logic       pc_ldz;
        logic [1:0] pc_src;
        logic [1:0] alu_fn;
        logic       a_sel;
        logic [1:0] b_sel;
        logic       rf_we;
        logic       rf_dst;
        logic       rf_wb;
    } ctl_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
    import mc_ctrl_pkg::*;
#(
    parameter int               OP_W  = 6,
    parameter logic [OP_W-1:0]  OP_RT = 6'b000000,
    parameter logic [OP_W-1:0]  OP_LD = 6'b100011,
    parameter logic [OP_W-1:0]  OP_ST = 6'b101011,
    parameter logic [OP_W-1:0]  OP_BR = 6'b000100,
    parameter logic [OP_W-1:0]  OP_JP = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output opclass_t        cls
);
    localparam int NCLS = 5;
    localparam logic [OP_W-1:0] CODES [NCLS] = '{OP_RT, OP_LD, OP_ST, OP_BR, OP_JP};

    logic [NCLS-1:0] hit;

    for (genvar g = 0; g < NCLS; g++) begin : g_match
        assign hit[g] = (opcode == CODES[g]);
    end

    always_comb begin
        cls = OC_OTHER;
        if      (hit[0]) cls = OC_RTYPE;
        else if (hit[1]) cls = OC_LOAD;
        else if (hit[2]) cls = OC_STORE;
        else if (hit[3]) cls = OC_BRANCH;
        else if (hit[4]) cls = OC_JUMP;
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_t   cur,
    input  opclass_t cls,
    output state_t   nxt
);
    always_comb begin
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                unique case (cls)
                    OC_RTYPE:  nxt = S_EXEC;
                    OC_LOAD,
                    OC_STORE:  nxt = S_MADDR;
                    OC_BRANCH: nxt = S_BRANCH;
                    OC_JUMP:   nxt = S_JUMP;
                    default:   nxt = S_FETCH;
                endcase
            end
            S_MADDR: begin
                if (cls == OC_LOAD)       nxt = S_LDMEM;
                else if (cls == OC_STORE) nxt = S_STMEM;
                else                      nxt = S_FETCH;
            end
            S_LDMEM:  nxt = S_LDWB;
            S_EXEC:   nxt = S_RWB;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
    import mc_ctrl_pkg::*;
(
    input  state_t cur,
    output ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            S_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_ld  = 1'b1;
                ctl.pc_ld  = 1'b1;
                ctl.pc_src = PCS_ALU;
                ctl.alu_fn = FN_ADD;
                ctl.b_sel  = BS_FOUR;
            end
            S_DECODE: begin
                ctl.alu_fn = FN_ADD;
                ctl.b_sel  = BS_IMMSH;
            end
            S_MADDR: begin
                ctl.a_sel  = 1'b1;
                ctl.b_sel  = BS_IMM;
                ctl.alu_fn = FN_ADD;
            end
            S_LDMEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            S_LDWB: begin
                ctl.rf_we = 1'b1;
                ctl.rf_wb = 1'b1;
            end
            S_STMEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_alu = 1'b1;
            end
            S_EXEC: begin
                ctl.a_sel  = 1'b1;
                ctl.b_sel  = BS_REG;
                ctl.alu_fn = FN_FIELD;
            end
            S_RWB: begin
                ctl.rf_we  = 1'b1;
                ctl.rf_dst = 1'b1;
            end
            S_BRANCH: begin
                ctl.a_sel  = 1'b1;
                ctl.b_sel  = BS_REG;
                ctl.alu_fn = FN_SUB;
                ctl.pc_ldz = 1'b1;
                ctl.pc_src = PCS_AREG;
            end
            S_JUMP: begin
                ctl.pc_ld  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic [3:0]      state_o,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic            ir_load,
    output logic            addr_from_alu,
    output logic            pc_load,
    output logic            pc_load_on_zero,
    output logic [1:0]      pc_src_sel,
    output logic [1:0]      alu_func_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            rf_wr_en,
    output logic            rf_dst_sel,
    output logic            rf_wb_sel
);
    typedef struct packed {
        state_t state;
    } regs_t;

    regs_t    reg_d, reg_q;
    opclass_t cls;
    state_t   nxt;
    ctl_t     ctl;

    mc_op_class #(.OP_W(OP_W)) u_class (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_next_state u_next (
        .cur (reg_q.state),
        .cls (cls),
        .nxt (nxt)
    );

    mc_ctl_decode u_dec (
        .cur (reg_q.state),
        .ctl (ctl)
    );

    always_comb begin
        reg_d = reg_q;
        if (rst) reg_d.state = S_FETCH;
        else     reg_d.state = nxt;
    end

    always_ff @(posedge clk) begin
        reg_q <= reg_d;
    end

    assign state_o         = reg_q.state;
    assign mem_rd_en       = ctl.mem_rd;
    assign mem_wr_en       = ctl.mem_wr;
    assign ir_load         = ctl.ir_ld;
    assign addr_from_alu   = ctl.addr_alu;
    assign pc_load         = ctl.pc_ld;
    assign pc_load_on_zero = ctl.pc_ldz;
    assign pc_src_sel      = ctl.pc_src;
    assign alu_func_sel    = ctl.alu_fn;
    assign alu_a_sel       = ctl.a_sel;
    assign alu_b_sel       = ctl.b_sel;
    assign rf_wr_en        = ctl.rf_we;
    assign rf_dst_sel      = ctl.rf_dst;
    assign rf_wb_sel       = ctl.rf_wb;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] state_o,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       ir_load,
    input logic       pc_load,
    input logic [1:0] pc_src_sel
);
    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> state_o == 4'd0);

    assert_fetch_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |-> (mem_rd_en && ir_load && pc_load && !mem_wr_en));

    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |=> state_o == 4'd1);

    assert_load_mem_to_wb_R4: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd3 |=> state_o == 4'd4);

    assert_store_returns_R5: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd5 |=> state_o == 4'd0);

    assert_exec_to_wb_R6: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd6 |=> state_o == 4'd7);

    assert_branch_returns_R7: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd8 |=> state_o == 4'd0);

    assert_jump_pc_R8: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd9 |-> (pc_load && pc_src_sel == 2'b10));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_o    (state_o),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .ir_load    (ir_load),
    .pc_load    (pc_load),
    .pc_src_sel (pc_src_sel)
);

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic [3:0] state_o;
    logic       mem_rd_en, mem_wr_en, ir_load, addr_from_alu, pc_load, pc_load_on_zero;
    logic [1:0] pc_src_sel, alu_func_sel, alu_b_sel;
    logic       alu_a_sel, rf_wr_en, rf_dst_sel, rf_wb_sel;

    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 1'b0;
    int    mstate  = 0;
    string ctx     = "";

    always #4 clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .ir_load(ir_load),
        .addr_from_alu(addr_from_alu), .pc_load(pc_load),
        .pc_load_on_zero(pc_load_on_zero), .pc_src_sel(pc_src_sel),
        .alu_func_sel(alu_func_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .rf_wr_en(rf_wr_en), .rf_dst_sel(rf_dst_sel), .rf_wb_sel(rf_wb_sel)
    );

    // Reference model: step numbers and per-step control words from the requirements.
    function automatic int model_next(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'b000000) return 6;
                if (op == 6'b100011 || op == 6'b101011) return 2;
                if (op == 6'b000100) return 8;
                if (op == 6'b000010) return 9;
                return 0;
            end
            2: begin
                if (op == 6'b100011) return 3;
                if (op == 6'b101011) return 5;
                return 0;
            end
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    // {rd,wr,ir,addr,pc,pcz,pcsrc[2],fn[2],a,b[2],we,dst,wb}
    function automatic logic [15:0] model_ctl(int s);
        case (s)
            0: return 16'hA808;
            1: return 16'h0018;
            2: return 16'h0030;
            3: return 16'h9000;
            4: return 16'h0005;
            5: return 16'h5000;
            6: return 16'h00A0;
            7: return 16'h0006;
            8: return 16'h0560;
            9: return 16'h0A00;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R4";
            5: return "R5";
            6, 7: return "R6";
            8: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) mstate <= rst ? 0 : model_next(mstate, opcode);

    task automatic check();
        logic [15:0] got, exp;
        string t;
        got = {mem_rd_en, mem_wr_en, ir_load, addr_from_alu, pc_load, pc_load_on_zero,
               pc_src_sel, alu_func_sel, alu_a_sel, alu_b_sel, rf_wr_en, rf_dst_sel, rf_wb_sel};
        exp = model_ctl(mstate);
        t = (ctx != "") ? ctx : tag_of(mstate);
        vectors++;
        if (state_o !== 4'(mstate) || got !== exp) begin
            errors++;
            $display("FAIL %s: state %0d ctl %h, expected state %0d ctl %h",
                     t, state_o, got, mstate, exp);
        end
    endtask

    // Opcode op1 is presented at decode, op2 at address compute; elsewhere random.
    task automatic run_instr(logic [5:0] op1, logic [5:0] op2, string c);
        ctx = c;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check();
            if (mstate == 1)      opcode = op1;
            else if (mstate == 2) opcode = op2;
            else                  opcode = 6'($urandom);
            if (mstate == 0 && i > 0) break;
        end
        ctx = "";
    endtask

    initial begin
        rst = 1'b1;
        opcode = 6'b100011;
        repeat (2) @(negedge clk);
        ctx = "R1";
        check();
        ctx = "";
        rst = 1'b0;
        opcode = 6'($urandom);

        run_instr(6'b100011, 6'b100011, "");      // load: R4
        run_instr(6'b101011, 6'b101011, "");      // store: R5
        run_instr(6'b000000, 6'b000000, "");      // register op: R6
        run_instr(6'b000100, 6'b000100, "");      // branch: R7
        run_instr(6'b000010, 6'b000010, "");      // jump: R8
        run_instr(6'b111111, 6'b111111, "R9");    // unlisted at decode
        run_instr(6'b001000, 6'b001000, "R9");
        run_instr(6'b101011, 6'b010001, "R9");    // unlisted at address compute
        run_instr(6'b100011, 6'b101011, "R5");    // load turned store at state 2
        run_instr(6'b000000, 6'b000000, "R10");   // random opcode outside 1 and 2
        run_instr(6'b100011, 6'b100011, "R10");

        // R11: reset in decode with a valid load opcode
        ctx = "R11";
        while (mstate != 1) begin
            @(negedge clk);
            check();
            opcode = 6'($urandom);
        end
        opcode = 6'b100011;
        rst = 1'b1;
        @(negedge clk);
        check();
        rst = 1'b0;
        @(negedge clk);
        check();
        ctx = "";

        for (int k = 0; k < 20; k++) begin
            case (k % 5)
                0: run_instr(6'b100011, 6'b100011, "");
                1: run_instr(6'b000100, 6'b000100, "");
                2: run_instr(6'b000000, 6'b000000, "");
                3: run_instr(6'b000010, 6'b000010, "");
                default: run_instr(6'b101011, 6'b101011, "");
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule